// File: doc/BRIEF.md
# Carry-less Polynomial Multiplier Unit

This unit is the execution stage of a binary-field multiply instruction. It takes two 128-bit source operands and an 8-bit immediate. The immediate picks the 64-bit half of each source that takes part. The unit returns the 128-bit product of the two halves, treated as polynomials with coefficients in GF(2). Partial products are combined with exclusive-OR, so no carry ever moves between bit positions.

The multiply loop handles eight multiplier bits per cycle. An optional second pass reduces the product modulo a programmable polynomial x^m + L(x) for GF(2^m) arithmetic. That pass folds every set coefficient at or above degree m back into the lower terms, working from the top bit down, and handles eight bit positions per cycle.

A request is a one-cycle `start` pulse, taken only while `busy` is low. The answer arrives as a one-cycle `res_valid` pulse. `result` holds its value until the next pulse.

Top module: `clmul_unit`

## Requirements
- R1: Bit k of the unreduced result is the XOR, over all i+j=k, of bit i of the selected half of `src_a` ANDed with bit j of the selected half of `src_b` (e.g. 4'b1101 times 4'b0111 gives 8'b00100011).
- R2: Immediate bit 0 picks the half of `src_a` and immediate bit 4 picks the half of `src_b`. For each, 0 selects bits [63:0] and 1 selects bits [127:64].
- R3: Immediate bits 1, 2, 3, 5, 6 and 7 have no effect on the result.
- R4: Without reduction, `res_valid` is high for exactly one cycle, 9 rising edges after the edge that accepted `start`.
- R5: With `reduce_en` set, the result is the product modulo x^m + L(x), where m is `red_deg` (1 to 127) and L(x) is `red_poly` bits below m. Bits of `red_poly` at or above m are ignored, and the result has no set bit at or above m.
- R6: With reduction, `res_valid` is high for exactly one cycle, 26 rising edges after the edge that accepted `start`.
- R7: `start` is accepted only while `busy` is low. A `start` while `busy` is high changes neither the operation in flight nor its result.
- R8: After reset, `busy` and `res_valid` are low and `result` is zero.
- R9: `result` changes only in a cycle where `res_valid` is high, and otherwise holds its value.

Port widths assume the default parameters (`HALF_W`=64, `DEG_W`=7), so bus widths below depend on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, taken only when `busy` is low |
| src_a | input | 128 | First source operand |
| src_b | input | 128 | Second source operand |
| imm | input | 8 | Half selector: bit 0 for `src_a`, bit 4 for `src_b` |
| reduce_en | input | 1 | Apply modular reduction after the multiply |
| red_deg | input | 7 | Degree m of the reduction polynomial |
| red_poly | input | 127 | Lower terms of the reduction polynomial; bits at or above m ignored |
| busy | output | 1 | Operation in progress |
| res_valid | output | 1 | One-cycle strobe marking a new result |
| result | output | 128 | Product, or reduced product |

## Verification
Every internal fault in this unit shows up in the single `result` word, or in the timing of `res_valid`, at the end of the operation that suffered it. That is 9 or 26 cycles after the request.

- A dropped or shifted partial product in the multiply loop corrupts the bits near the affected position in that operation's result.
- A wrong half select makes the result match a different operand pair.
- A fold applied below m, or skipped above it, leaves set bits at or above m, or gives a remainder that disagrees with an independently computed one.
- A counter that ends one step early or late moves the strobe, so the measured latency of every request exposes it.

// File: rtl/clmul_pkg.sv
package clmul_pkg;
  localparam int HALF_W   = 64;
  localparam int PROD_W   = 2 * HALF_W;
  localparam int STEP     = 8;
  localparam int DEG_W    = $clog2(PROD_W);
  localparam int IMM_W    = 8;
  localparam int SEL_A_IX = 0;
  localparam int SEL_B_IX = 4;

  // carry-less product of a by a STEP-bit slice of the multiplier
  function automatic logic [PROD_W-1:0] clmul_slice(input logic [HALF_W-1:0] a,
                                                    input logic [STEP-1:0] s);
    logic [PROD_W-1:0] r;
    r = '0;
    for (int j = 0; j < STEP; j++)
      if (s[j]) r = r ^ ({{HALF_W{1'b0}}, a} << j);
    return r;
  endfunction

  // lower terms of the modulus, masked below degree m
  function automatic logic [PROD_W-2:0] low_terms(input logic [PROD_W-2:0] p,
                                                  input logic [DEG_W-1:0] m);
    logic [PROD_W-1:0] mask;
    mask = ({{(PROD_W-1){1'b0}}, 1'b1} << m) - 1'b1;
    return p & mask[PROD_W-2:0];
  endfunction

  // fold bit positions top..top-STEP+1 that sit at or above degree m
  function automatic logic [PROD_W-1:0] fold_slice(input logic [PROD_W-1:0] r_in,
                                                   input logic [PROD_W-2:0] low,
                                                   input logic [DEG_W-1:0] m,
                                                   input logic [DEG_W-1:0] top);
    logic [PROD_W-1:0] r;
    int i;
    r = r_in;
    for (int k = 0; k < STEP; k++) begin
      i = int'(top) - k;
      if (i >= int'(m) && r[i]) begin
        r[i] = 1'b0;
        r = r ^ ({1'b0, low} << (i - int'(m)));
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/clmul_mul_core.sv
module clmul_mul_core
  import clmul_pkg::*;
#(
  parameter int HW = HALF_W,
  parameter int SW = STEP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [HW-1:0] op_a,
  input  logic [HW-1:0] op_b,
  output logic          busy,
  output logic          done,
  output logic [2*HW-1:0] prod
);
  localparam int NSTEPS = HW / SW;
  localparam int CW     = (NSTEPS > 1) ? $clog2(NSTEPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(NSTEPS - 1);

  logic [HW-1:0] a_q, b_q;
  logic [CW-1:0] cnt;
  logic          run;
  logic          last_step;

  assign last_step = run && (cnt == LAST);
  assign busy      = run | done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      b_q  <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
      prod <= '0;
    end else begin
      done <= last_step;
      if (go && !busy) begin
        a_q  <= op_a;
        b_q  <= op_b;
        cnt  <= '0;
        run  <= 1'b1;
        prod <= '0;
      end else if (run) begin
        prod <= (prod << SW) ^ clmul_slice(a_q, b_q[HW-1 -: SW]);
        b_q  <= b_q << SW;
        cnt  <= cnt + 1'b1;
        if (last_step) run <= 1'b0;
      end
    end
  end

  // R4
  mul_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/clmul_reducer.sv
module clmul_reducer
  import clmul_pkg::*;
#(
  parameter int PW = PROD_W,
  parameter int SW = STEP,
  parameter int DW = DEG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [PW-1:0] prod_in,
  input  logic [DW-1:0] deg,
  input  logic [PW-2:0] poly,
  output logic          busy,
  output logic          done,
  output logic [PW-1:0] rem_out
);
  localparam int NCHUNK = PW / SW;
  localparam int CW     = (NCHUNK > 1) ? $clog2(NCHUNK) : 1;
  localparam logic [CW-1:0] LAST = CW'(NCHUNK - 1);
  localparam logic [DW-1:0] TOP0 = DW'(PW - 1);

  logic [PW-2:0] low_q;
  logic [DW-1:0] m_q, pos;
  logic [CW-1:0] cnt;
  logic          run;
  logic          last_step;

  assign last_step = run && (cnt == LAST);
  assign busy      = run | done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q   <= '0;
      m_q     <= '0;
      pos     <= '0;
      cnt     <= '0;
      run     <= 1'b0;
      done    <= 1'b0;
      rem_out <= '0;
    end else begin
      done <= last_step;
      if (go && !busy) begin
        low_q   <= low_terms(poly, deg);
        m_q     <= deg;
        pos     <= TOP0;
        cnt     <= '0;
        run     <= 1'b1;
        rem_out <= prod_in;
      end else if (run) begin
        rem_out <= fold_slice(rem_out, low_q, m_q, pos);
        pos     <= pos - DW'(SW);
        cnt     <= cnt + 1'b1;
        if (last_step) run <= 1'b0;
      end
    end
  end

  // R5
  red_degree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((rem_out >> m_q) == '0));
endmodule

// File: rtl/clmul_unit.sv
module clmul_unit
  import clmul_pkg::*;
#(
  parameter int HW = HALF_W,
  parameter int SW = STEP,
  parameter int DW = DEG_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2*HW-1:0] src_a,
  input  logic [2*HW-1:0] src_b,
  input  logic [IMM_W-1:0] imm,
  input  logic            reduce_en,
  input  logic [DW-1:0]   red_deg,
  input  logic [2*HW-2:0] red_poly,
  output logic            busy,
  output logic            res_valid,
  output logic [2*HW-1:0] result
);
  localparam int PW = 2 * HW;
  localparam logic [IMM_W-1:0] SEL_A_MASK = IMM_W'(1) << SEL_A_IX;
  localparam logic [IMM_W-1:0] SEL_B_MASK = IMM_W'(1) << SEL_B_IX;

  logic          sel_a_hi, sel_b_hi;
  logic [HW-1:0] half_a, half_b;
  logic          accept;
  logic          mul_busy, mul_done, red_busy, red_done;
  logic [PW-1:0] mul_prod, red_rem;
  logic          red_en_q;
  logic [DW-1:0] deg_q;
  logic [PW-2:0] poly_q;
  logic          plain_finish, red_finish;

  // only the two selector bits reach the decode
  assign sel_a_hi = |(imm & SEL_A_MASK);
  assign sel_b_hi = |(imm & SEL_B_MASK);
  assign half_a   = sel_a_hi ? src_a[PW-1:HW] : src_a[HW-1:0];
  assign half_b   = sel_b_hi ? src_b[PW-1:HW] : src_b[HW-1:0];

  assign busy         = mul_busy | red_busy;
  assign accept       = start && !busy;
  assign plain_finish = mul_done && !red_en_q;
  assign red_finish   = red_done;

  clmul_mul_core #(.HW(HW), .SW(SW)) mul_i (
    .clk(clk), .rst_n(rst_n), .go(accept),
    .op_a(half_a), .op_b(half_b),
    .busy(mul_busy), .done(mul_done), .prod(mul_prod)
  );

  clmul_reducer #(.PW(PW), .SW(SW), .DW(DW)) red_i (
    .clk(clk), .rst_n(rst_n), .go(mul_done && red_en_q),
    .prod_in(mul_prod), .deg(deg_q), .poly(poly_q),
    .busy(red_busy), .done(red_done), .rem_out(red_rem)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      red_en_q  <= 1'b0;
      deg_q     <= '0;
      poly_q    <= '0;
      res_valid <= 1'b0;
      result    <= '0;
    end else begin
      if (accept) begin
        red_en_q <= reduce_en;
        deg_q    <= red_deg;
        poly_q   <= red_poly;
      end
      res_valid <= plain_finish | red_finish;
      if (plain_finish)    result <= mul_prod;
      else if (red_finish) result <= red_rem;
    end
  end

  // R4
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(result));
  // R7
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R7
  single_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mul_busy && red_busy));
endmodule

// File: tb/clmul_unit_tb_top.sv
module clmul_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] src_a = '0, src_b = '0;
  logic [7:0]   imm = '0;
  logic         reduce_en = 1'b0;
  logic [6:0]   red_deg = '0;
  logic [126:0] red_poly = '0;
  logic         busy, res_valid;
  logic [127:0] result;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;

  clmul_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .src_a(src_a), .src_b(src_b),
    .imm(imm), .reduce_en(reduce_en), .red_deg(red_deg), .red_poly(red_poly),
    .busy(busy), .res_valid(res_valid), .result(result)
  );

  function automatic logic [127:0] ref_mul(input logic [63:0] a, input logic [63:0] b);
    logic [127:0] p = '0;
    for (int i = 0; i < 64; i++)
      for (int j = 0; j < 64; j++)
        p[i+j] = p[i+j] ^ (a[i] & b[j]);
    return p;
  endfunction

  // remainder built from running powers x^i mod P
  function automatic logic [127:0] ref_red(input logic [127:0] p, input int m,
                                           input logic [126:0] poly);
    logic [127:0] lo, pw, rem;
    lo = '0;
    for (int i = 0; i < m; i++) lo[i] = poly[i];
    rem = '0;
    for (int i = 0; i < m; i++) rem[i] = p[i];
    pw = lo;
    for (int i = m; i < 128; i++) begin
      if (p[i]) rem = rem ^ pw;
      pw = pw << 1;
      if (pw[m]) begin
        pw[m] = 1'b0;
        pw = pw ^ lo;
      end
    end
    return rem;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [127:0] a, input logic [127:0] b,
                        input logic [7:0] im, input logic ren, input logic [6:0] m,
                        input logic [126:0] pl, output logic [127:0] res,
                        output int lat);
    @(negedge clk);
    while (busy) @(negedge clk);
    src_a = a; src_b = b; imm = im; reduce_en = ren; red_deg = m; red_poly = pl;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!res_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    res = result;
  endtask

  logic [127:0] r, e, la, lb;
  int lat;

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(!busy && !res_valid && result == '0, "R8", {126'b0, busy, res_valid}, '0);
    chk(result == '0, "R8", result, '0);
    rst_n = 1'b1;

    // R1 reference case and R4 latency
    run_op(128'hD, 128'h7, 8'h00, 1'b0, 7'd0, '0, r, lat);
    chk(r == 128'h23, "R1", r, 128'h23);
    chk(lat == 9, "R4", 128'(lat), 128'd9);
    @(negedge clk);
    chk(!res_valid, "R4", {127'b0, res_valid}, '0);

    // R1 exhaustive 4-bit by 4-bit
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++) begin
        run_op(128'(x), 128'(y), 8'h00, 1'b0, 7'd0, '0, r, lat);
        e = ref_mul(64'(x), 64'(y));
        chk(r == e, "R1", r, e);
      end

    // R1 walking single bits
    for (int i = 0; i < 64; i += 9)
      for (int j = 0; j < 64; j += 7) begin
        run_op(128'(1) << i, 128'(1) << j, 8'h00, 1'b0, 7'd0, '0, r, lat);
        e = 128'(1) << (i + j);
        chk(r == e, "R1", r, e);
      end
    run_op('1, '1, 8'h00, 1'b0, 7'd0, '0, r, lat);
    e = ref_mul('1, '1);
    chk(r == e, "R1", r, e);

    // R2 all four half combinations, R3 with noise in other bits
    la = {64'hA5A5_0F0F_3C3C_9999, 64'h1234_5678_9ABC_DEF0};
    lb = {64'hFEDC_BA98_7654_3210, 64'h0BAD_F00D_CAFE_BEEF};
    for (int s = 0; s < 4; s++) begin
      logic [7:0] im;
      im = {3'b000, s[1], 3'b000, s[0]};
      e = ref_mul(s[0] ? la[127:64] : la[63:0], s[1] ? lb[127:64] : lb[63:0]);
      run_op(la, lb, im, 1'b0, 7'd0, '0, r, lat);
      chk(r == e, "R2", r, e);
      run_op(la, lb, im | 8'hEE, 1'b0, 7'd0, '0, r, lat);
      chk(r == e, "R3", r, e);
    end

    // R1/R2 pseudo-random operands
    la = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3211;
    lb = 128'h9E37_79B9_7F4A_7C15_F39C_C060_5CED_C835;
    for (int k = 0; k < 24; k++) begin
      la = {la[126:0], la[127] ^ la[125] ^ la[100] ^ la[98]};
      lb = lb ^ (lb << 13) ^ (la >> 7);
      e = ref_mul(k[0] ? la[127:64] : la[63:0], k[1] ? lb[127:64] : lb[63:0]);
      run_op(la, lb, {3'b0, k[1], 3'b0, k[0]}, 1'b0, 7'd0, '0, r, lat);
      chk(r == e, "R2", r, e);
    end

    // R5 GF(2^8): 0x57 * 0x83 mod x^8+x^4+x^3+x+1 = 0xC1, upper poly bits ignored
    run_op(128'h57, 128'h83, 8'h00, 1'b1, 7'd8, {119'h55_AAAA, 8'h1B}, r, lat);
    chk(r == 128'hC1, "R5", r, 128'hC1);
    chk(lat == 26, "R6", 128'(lat), 128'd26);
    @(negedge clk);
    chk(!res_valid, "R6", {127'b0, res_valid}, '0);

    // R5 degrees across the range
    foreach (la[k]) begin
      if (k < 6) begin
        int mdeg;
        logic [126:0] pl;
        mdeg = (k == 0) ? 1 : (k == 1) ? 7 : (k == 2) ? 63 : (k == 3) ? 64 : (k == 4) ? 100 : 127;
        pl = {lb[126:0]} ^ 127'h87;
        e = ref_red(ref_mul(la[63:0], lb[127:64]), mdeg, pl);
        run_op(la, lb, 8'h10, 1'b1, 7'(mdeg), pl, r, lat);
        chk(r == e, "R5", r, e);
        la = la ^ (la << 5) ^ 128'h3;
      end
    end

    // R7 start while busy is ignored
    @(negedge clk);
    src_a = 128'h5; src_b = 128'h3; imm = 8'h00; reduce_en = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy, "R7", {127'b0, busy}, 128'd1);
    src_a = 128'hFF; src_b = 128'hFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!res_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk(result == 128'hF, "R7", result, 128'hF);
    r = result;
    repeat (12) @(negedge clk);
    chk(!res_valid && !busy, "R7", {126'b0, busy, res_valid}, '0);
    // R9 hold
    chk(result == r, "R9", result, r);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule